// File: doc/BRIEF.md
# Block-floating-point output exponent aligner

This block sits after a block-floating-point FFT and brings every output word back to one fixed binary weighting. Each incoming 16-bit word arrives with its 2-bit word tag and the 5-bit two's complement global weighting value that applied to its pass. The block works out how far the binary point of that word has moved, compares this with a programmable target exponent, and shifts the word right arithmetically by the difference. After this, all words from the transform share one scale and can be compared or stored directly. A target exponent of log2(N) is enough for an N-point transform. How that target is chosen is left to the user.

Complex samples arrive as two words, real first and imaginary second, on valid cycles that need not be back to back. A two-state sequencer (`PH_REAL`, `PH_IMAG`) tracks which half is expected. In `PH_REAL` a valid word takes the freshly computed shift, the block stores that shift, and the sequencer moves to `PH_IMAG`. In `PH_IMAG` a valid word reuses the stored shift and the sequencer returns to `PH_REAL`. A cycle without a valid word leaves the state where it is. The path has two register stages, and a valid flag travels alongside the data.

The shift is computed with a shortcut. The raw tag is added to the global value, and the target is raised by one to make up for it. The result is clamped to the range 0 to 15. The upper clamp acts as the trap for very negative global values.

Top module: `nrm_exp_align`

## Requirements
- R1: While reset is asserted and right after it, out_valid, out_imag and out_data are all 0, and the sequencer expects a real word.
- R2: out_valid equals in_valid delayed by two clock edges. The word presented with in_valid high before edge k appears on out_data after edge k+1.
- R3: For a real word, the shift is S = (U + 1) - (G + T). Here U is in_uexp read as unsigned 0..31, G is in_gwr read as 5-bit two's complement (-16..15), and T is in_tag read as unsigned 0..3 (tag 0 means one place below the global weighting and tag 3 means two places above). out_data equals in_data shifted right arithmetically by S.
- R4: If S is negative, the shift is 0 and the word passes through unchanged.
- R5: If S is greater than 15 (for example, a very negative global value), the shift is forced to 15.
- R6: The shift fills from the left with the sign bit, so bit 15 of out_data always equals bit 15 of the input word.
- R7: Valid words alternate between real and imaginary, starting with real after reset. out_imag is 0 for a real word and 1 for an imaginary word.
- R8: An imaginary word is shifted by the amount computed for the real word before it. Its own in_tag, in_gwr and in_uexp have no effect.
- R9: Cycles with in_valid low do not move the sequencer between halves. Two cycles later they give out_valid low, and out_data keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A word is presented this cycle |
| in_data | input | 16 | Two's complement data word |
| in_tag | input | 2 | Word tag of this word |
| in_gwr | input | 5 | Global weighting value, two's complement |
| in_uexp | input | 5 | Target exponent, unsigned |
| out_valid | output | 1 | out_data holds a new result |
| out_imag | output | 1 | Result is the imaginary half of a sample |
| out_data | output | 16 | Realigned word |

## Verification
The hardest case to reach is an imaginary word that carries a tag, global value and target different from its real partner, with idle cycles in between. In that case a wrong design would silently apply a fresh shift or lose its phase. The bench sweeps every combination of target, global value and tag. It gives each imaginary word a deliberately different tag, global value and target, and it inserts idle cycles between halves at regular intervals. Because global values run down to -16 and targets up to 31, both the zero clamp and the 15-place trap are reached many times.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
    typedef enum logic {
        PH_REAL = 1'b0,
        PH_IMAG = 1'b1
    } part_phase_e;
endpackage

// File: rtl/nrm_shift_calc.sv
module nrm_shift_calc #(
    parameter int TAG_W = 2,
    parameter int GWR_W = 5,
    parameter int UX_W  = 5,
    parameter int SH_W  = 4
) (
    input  logic [TAG_W-1:0] tag,
    input  logic [GWR_W-1:0] gwr,
    input  logic [UX_W-1:0]  uexp,
    output logic [SH_W-1:0]  shift
);
    localparam int BASE_W = (GWR_W > UX_W) ? GWR_W : UX_W;
    localparam int CW     = BASE_W + 3;
    localparam logic [CW-1:0] SH_MAX = CW'((1 << SH_W) - 1);

    logic [CW-1:0] gwr_x;
    logic [CW-1:0] tag_x;
    logic [CW-1:0] target;
    logic [CW-1:0] exp_sum;
    logic [CW-1:0] diff;
    logic          too_low;
    logic          too_high;

    always_comb begin
        gwr_x    = {{(CW-GWR_W){gwr[GWR_W-1]}}, gwr};
        tag_x    = {{(CW-TAG_W){1'b0}}, tag};
        // raw tag is added; the target is raised by one to compensate
        target   = {{(CW-UX_W){1'b0}}, uexp} + CW'(1);
        exp_sum  = gwr_x + tag_x;
        diff     = target - exp_sum;
        too_low  = diff[CW-1];
        too_high = !too_low && (diff > SH_MAX);
        if (too_low)
            shift = '0;
        else if (too_high)
            shift = SH_MAX[SH_W-1:0];
        else
            shift = diff[SH_W-1:0];
    end
endmodule

// File: rtl/nrm_phase_fsm.sv
module nrm_phase_fsm
    import nrm_pkg::*;
#(
    parameter int SH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_valid,
    input  logic [SH_W-1:0] new_shift,
    output logic [SH_W-1:0] use_shift,
    output logic            part_imag
);
    part_phase_e     state_q;
    part_phase_e     state_d;
    logic [SH_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_REAL;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (word_valid && state_q == PH_REAL)
            held_q <= new_shift;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_REAL: if (word_valid) state_d = PH_IMAG;
            PH_IMAG: if (word_valid) state_d = PH_REAL;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PH_REAL: begin
                use_shift = new_shift;
                part_imag = 1'b0;
            end
            PH_IMAG: begin
                use_shift = held_q;
                part_imag = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/nrm_barrel.sv
module nrm_barrel #(
    parameter int DATA_W = 16,
    parameter int SH_W   = 4
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] acc;

    always_comb begin
        acc = din;
        for (int i = 0; i < SH_W; i++) begin
            if (amt[i])
                acc = DATA_W'($signed(acc) >>> (1 << i));
        end
        dout = acc;
    end
endmodule

// File: rtl/nrm_exp_align.sv
module nrm_exp_align #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 2,
    parameter int GWR_W  = 5,
    parameter int UX_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [GWR_W-1:0]  in_gwr,
    input  logic [UX_W-1:0]   in_uexp,
    output logic              out_valid,
    output logic              out_imag,
    output logic [DATA_W-1:0] out_data
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   calc_shift;
    logic [SH_W-1:0]   use_shift;
    logic              part_imag;
    logic              s1_valid;
    logic              s1_imag;
    logic [DATA_W-1:0] s1_data;
    logic [SH_W-1:0]   s1_shift;
    logic [DATA_W-1:0] shifted;

    nrm_shift_calc #(
        .TAG_W(TAG_W), .GWR_W(GWR_W), .UX_W(UX_W), .SH_W(SH_W)
    ) u_calc (
        .tag(in_tag), .gwr(in_gwr), .uexp(in_uexp), .shift(calc_shift)
    );

    nrm_phase_fsm #(.SH_W(SH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .word_valid(in_valid),
        .new_shift(calc_shift), .use_shift(use_shift), .part_imag(part_imag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_imag  <= 1'b0;
            s1_data  <= '0;
            s1_shift <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_imag  <= part_imag;
                s1_data  <= in_data;
                s1_shift <= use_shift;
            end
        end
    end

    nrm_barrel #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .din(s1_data), .amt(s1_shift), .dout(shifted)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_imag  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_imag <= s1_imag;
                out_data <= shifted;
            end
        end
    end
endmodule

// File: rtl/nrm_exp_align_chk.sv
module nrm_exp_align_chk #(
    parameter int SH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_sign,
    input logic            out_valid,
    input logic            out_imag,
    input logic            out_sign,
    input logic            s1_valid,
    input logic            s1_imag,
    input logic [SH_W-1:0] s1_shift
);
    logic            v1, v2;
    logic            g1, g2;
    logic            last_imag;
    logic [SH_W-1:0] real_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            g1        <= 1'b0;
            g2        <= 1'b0;
            last_imag <= 1'b1;
            real_sh   <= '0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            g1 <= in_sign;
            g2 <= g1;
            if (out_valid)
                last_imag <= out_imag;
            if (s1_valid && !s1_imag)
                real_sh <= s1_shift;
        end
    end

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2);

    p_sign_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sign == g2);

    p_halves_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_imag != last_imag);

    p_imag_reuses_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_imag) |-> s1_shift == real_sh);
endmodule

bind nrm_exp_align nrm_exp_align_chk #(.SH_W(SH_W)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(in_valid),
    .in_sign(in_data[DATA_W-1]),
    .out_valid(out_valid),
    .out_imag(out_imag),
    .out_sign(out_data[DATA_W-1]),
    .s1_valid(s1_valid),
    .s1_imag(s1_imag),
    .s1_shift(s1_shift)
);

// File: tb/test_nrm_exp_align.sv
`timescale 1ns/1ps
module test_nrm_exp_align;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [1:0]  in_tag = '0;
    logic [4:0]  in_gwr = '0;
    logic [4:0]  in_uexp = '0;
    logic        out_valid;
    logic        out_imag;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic        m_imag = 1'b0;
    int          m_sh = 0;
    logic        ev1 = 1'b0, ev2 = 1'b0;
    logic        ei1 = 1'b0, ei2 = 1'b0;
    logic [15:0] ed1 = '0, ed2 = '0;
    string       er1 = "R3", er2 = "R3";
    logic [15:0] last_d = '0;
    int          word_k = 0;

    always #5 clk = ~clk;

    nrm_exp_align i_nrm_exp_align (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_tag(in_tag), .in_gwr(in_gwr), .in_uexp(in_uexp),
        .out_valid(out_valid), .out_imag(out_imag), .out_data(out_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_shift(input int g, input int t, input int u,
                                       output string why);
        int d;
        d = u + 1 - (g + t);
        why = "R3";
        if (d < 0) begin
            why = "R4";
            d = 0;
        end else if (d > 15) begin
            why = "R5";
            d = 15;
        end
        return d;
    endfunction

    task automatic tick(input logic v, input logic [15:0] d,
                        input int t, input int g, input int u);
        string why;
        int    sh;
        @(negedge clk);
        if (ev2) begin
            chk("R2 out_valid", int'(out_valid), 1);
            chk("R7 out_imag", int'(out_imag), int'(ei2));
            chk({er2, " out_data"}, int'(out_data), int'(ed2));
            last_d = ed2;
        end else begin
            chk("R2 out_valid idle", int'(out_valid), 0);
            chk("R9 out_data hold", int'(out_data), int'(last_d));
        end
        ev2 = ev1; ei2 = ei1; ed2 = ed1; er2 = er1;
        ev1 = v;
        if (v) begin
            if (!m_imag) begin
                sh = model_shift(g, t, u, why);
                m_sh = sh;
                if (why == "R3" && d[15]) why = "R6";
                ei1 = 1'b0;
            end else begin
                sh = m_sh;
                why = "R8";
                ei1 = 1'b1;
            end
            m_imag = ~m_imag;
            ed1 = 16'($signed(d) >>> sh);
            er1 = why;
        end
        in_valid = v;
        in_data  = d;
        in_tag   = 2'(t);
        in_gwr   = 5'(g);
        in_uexp  = 5'(u);
    endtask

    initial begin
        int n;
        logic [15:0] dr, di;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_imag", int'(out_imag), 0);
        chk("R1 out_data", int'(out_data), 0);
        rst_n = 1'b1;
        n = 0;
        for (int u = 0; u < 32; u++) begin
            for (int g = -16; g < 16; g++) begin
                for (int t = 0; t < 4; t++) begin
                    word_k++;
                    dr = 16'(word_k * 40503 + 12345);
                    di = 16'(word_k * 25173 + 13849);
                    tick(1'b1, dr, t, g, u);
                    n++;
                    if (n % 5 == 0) tick(1'b0, 16'hDEAD, 3, -16, 31);
                    // imaginary half carries unrelated controls: ignored (R8)
                    tick(1'b1, di, (t + 1) % 4, (g + 7) % 16, (u + 13) % 32);
                    if (n % 7 == 0) tick(1'b0, 16'h1234, 0, 15, 0);
                end
            end
        end
        repeat (3) tick(1'b0, 16'h0, 0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule